// File: doc/BRIEF.md
# Hit-Map Driven Event Readout Sequencer

This block drains one accepted event from a group of front-end time-to-digital converter chips and turns it into a framed record for an output FIFO. The chips sit on several boards, and each board carries the same number of chips. The sequencer visits every chip once, in a fixed order. For each chip it fetches a channel hit map. A chip whose map is empty is passed over without any further access. For a chip with hits, the sequencer emits an address word, the map itself, the chip's event tag and its counter value. It then walks the channels. For each channel it emits the channel number, issues a read start to the chip, and copies that channel's data words until the chip flags the last one.

A zero-suppression option is captured when an event is accepted. With the option on, channels whose hit-map bit is clear are left out of the frame. Once the last chip has been handled, a pending-event read pointer advances and the block goes idle.

Both the start request and the output use valid/ready handshakes. A start is taken only on a cycle in which `start_valid` and `start_ready` are both high. An output word is transferred on a cycle in which `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the sequencer holds its state and the word it is presenting, and it does not consume a chip word. Every output word carries a 3-bit kind field in bits [18:16] and a 16-bit payload in bits [15:0].

Top module: `hitmap_readout_seq`

## Requirements
- R1: After reset `busy` is low and `start_ready` is high. `start_ready` is high exactly when the block is idle. A start accepted at a clock edge makes `busy` high from the next cycle until the frame is complete, and `start_ready` stays low for the same span.
- R2: The first word of every frame has kind 1 and carries the `start_evt` value captured at acceptance, zero-extended, as its payload.
- R3: Chips are visited in ascending flat index, where the flat index is board × chips-per-board + chip. For each chip the hit map is read with op code 1 on `chip_op`. A chip whose map is zero adds no word to the frame and receives no other chip access.
- R4: For a chip with a nonzero map, the frame carries an address word next (kind 2, payload = flat chip index), followed by a hit-map word (kind 3, payload = the map).
- R5: After the hit-map word come a tag word (kind 4) and then a counter word (kind 5). Each of their payloads is the `chip_data` value returned while `chip_op` is 2 (tag) or 3 (counter).
- R6: For each channel that is read out, the frame carries a channel word (kind 6, payload = channel number). One cycle with `chip_op` = 4 (read start) follows. After that come data words (kind 7) taken from `chip_data` while `chip_op` = 5, up to and including the word on which `chip_eoc` is high.
- R7: `zero_supp` is captured when a start is accepted. When it is captured high, channels whose hit-map bit is clear produce no words. When it is captured low, every channel of a chip with hits is read in ascending order. Changing `zero_supp` during a frame has no effect on that frame.
- R8: While `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high with the same `out_data`. No chip word is consumed, so no word is lost or duplicated. `chip_ack` marks the cycles in which the chip's current word is taken.
- R9: After the last chip, `evt_rd_ptr` increases by one (modulo 2^EVT_W) and `busy` falls in the same cycle. `evt_rd_ptr` is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start request for one event |
| start_ready | output | 1 | High when a start can be accepted (idle) |
| start_evt | input | EVT_W | Event index placed in the frame header |
| zero_supp | input | 1 | Zero-suppression option, captured at start |
| busy | output | 1 | High while a frame is being built |
| evt_rd_ptr | output | EVT_W | Pending-event read pointer |
| chip_sel | output | clog2(boards×chips) | Flat index of the chip being accessed |
| chip_chan | output | clog2(CHANS) | Channel being accessed |
| chip_op | output | 3 | 0 none, 1 hit map, 2 tag, 3 counter, 4 read start, 5 data word |
| chip_ack | output | 1 | The chip's current word is taken this cycle |
| chip_data | input | DATA_W | Chip read data, valid in the same cycle as `chip_op` |
| chip_eoc | input | 1 | Current data word is the channel's last |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | FIFO can accept a word |
| out_data | output | 3+DATA_W | {kind, payload} |

## Verification
The bench sweeps twelve events. Each event has its own hit-map pattern, and the patterns include chips with empty maps and one event in which every map is empty. The sweep alternates suppression on and off and flips `zero_supp` in the middle of each frame. A design that read empty chips, ignored the captured option or re-sampled it would produce a frame of the wrong length, or with channel words where none belong. Three back-pressure patterns, up to random stalls, show whether a stalled word changes or a chip word is popped twice; either fault skews the data sequence. The single-word header-only frame and the pointer step after each event show whether the end sequencing is off by one.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  localparam int KIND_W = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_SOF, S_RD_HMAP, S_CHK_HMAP, S_WR_ADDR, S_WR_HMAP,
    S_RD_TAG, S_RD_CNT, S_CHAN, S_RD_START, S_RD_WORD,
    S_NEXT_CHAN, S_NEXT_CHIP, S_INC_PTR
  } seq_state_t;

  typedef enum logic [2:0] {
    K_NONE = 3'd0, K_SOF = 3'd1, K_ADDR = 3'd2, K_HMAP = 3'd3,
    K_TAG = 3'd4, K_CNT = 3'd5, K_CHAN = 3'd6, K_DATA = 3'd7
  } word_kind_t;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_HMAP = 3'd1, OP_TAG = 3'd2, OP_CNT = 3'd3,
    OP_START = 3'd4, OP_WORD = 3'd5
  } chip_op_t;

endpackage

// File: rtl/rdseq_index.sv
module rdseq_index #(
  parameter int NUM_CHIPS = 8,
  parameter int CHANS     = 8,
  parameter int EVT_W     = 8,
  localparam int CHIP_W   = $clog2(NUM_CHIPS),
  localparam int CHAN_W   = $clog2(CHANS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              inc_chip,
  input  logic              clr_chan,
  input  logic              inc_chan,
  input  logic              inc_ptr,
  output logic [CHIP_W-1:0] chip_idx,
  output logic [CHAN_W-1:0] chan_idx,
  output logic [EVT_W-1:0]  rd_ptr,
  output logic              last_chip,
  output logic              last_chan
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chip_idx <= '0;
      chan_idx <= '0;
      rd_ptr   <= '0;
    end else begin
      if (clr_all) begin
        chip_idx <= '0;
        chan_idx <= '0;
      end else begin
        if (inc_chip) chip_idx <= chip_idx + 1'b1;
        if (clr_chan)      chan_idx <= '0;
        else if (inc_chan) chan_idx <= chan_idx + 1'b1;
      end
      if (inc_ptr) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign last_chip = (chip_idx == CHIP_W'(NUM_CHIPS - 1));
  assign last_chan = (chan_idx == CHAN_W'(CHANS - 1));

  // R3
  chip_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_chip |-> !last_chip);

  // R6
  chan_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_chan |-> !last_chan);

endmodule

// File: rtl/rdseq_frame.sv
module rdseq_frame
  import rdseq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHANS  = 8,
  parameter int CHIP_W = 3,
  parameter int CHAN_W = 3,
  parameter int EVT_W  = 8
) (
  input  seq_state_t                state,
  input  logic                      chan_skip,
  input  logic [EVT_W-1:0]          evt,
  input  logic [CHIP_W-1:0]         chip_idx,
  input  logic [CHAN_W-1:0]         chan_idx,
  input  logic [CHANS-1:0]          hmap,
  input  logic [DATA_W-1:0]         chip_data,
  output logic                      valid,
  output logic [KIND_W+DATA_W-1:0]  data
);

  word_kind_t        kind;
  logic [DATA_W-1:0] payload;

  always_comb begin
    kind    = K_NONE;
    payload = '0;
    unique case (state)
      S_SOF:     begin kind = K_SOF;  payload = DATA_W'(evt);      end
      S_WR_ADDR: begin kind = K_ADDR; payload = DATA_W'(chip_idx); end
      S_WR_HMAP: begin kind = K_HMAP; payload = DATA_W'(hmap);     end
      S_RD_TAG:  begin kind = K_TAG;  payload = chip_data;         end
      S_RD_CNT:  begin kind = K_CNT;  payload = chip_data;         end
      S_CHAN: begin
        if (!chan_skip) begin
          kind    = K_CHAN;
          payload = DATA_W'(chan_idx);
        end
      end
      S_RD_WORD: begin kind = K_DATA; payload = chip_data;         end
      default: ;
    endcase
  end

  assign valid = (kind != K_NONE);
  assign data  = {kind, payload};

endmodule

// File: rtl/hitmap_readout_seq.sv
module hitmap_readout_seq
  import rdseq_pkg::*;
#(
  parameter int NUM_BOARDS      = 4,
  parameter int CHIPS_PER_BOARD = 2,
  parameter int CHANS           = 8,
  parameter int DATA_W          = 16,
  parameter int EVT_W           = 8
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          start_valid,
  output logic                                          start_ready,
  input  logic [EVT_W-1:0]                              start_evt,
  input  logic                                          zero_supp,
  output logic                                          busy,
  output logic [EVT_W-1:0]                              evt_rd_ptr,
  output logic [$clog2(NUM_BOARDS*CHIPS_PER_BOARD)-1:0] chip_sel,
  output logic [$clog2(CHANS)-1:0]                      chip_chan,
  output logic [2:0]                                    chip_op,
  output logic                                          chip_ack,
  input  logic [DATA_W-1:0]                             chip_data,
  input  logic                                          chip_eoc,
  output logic                                          out_valid,
  input  logic                                          out_ready,
  output logic [2+DATA_W:0]                             out_data
);

  localparam int NUM_CHIPS = NUM_BOARDS * CHIPS_PER_BOARD;
  localparam int CHIP_W    = $clog2(NUM_CHIPS);
  localparam int CHAN_W    = $clog2(CHANS);

  seq_state_t         state_q, state_d;
  logic [CHANS-1:0]   hmap_q;
  logic [EVT_W-1:0]   evt_q;
  logic               zs_q;
  logic [CHIP_W-1:0]  chip_idx;
  logic [CHAN_W-1:0]  chan_idx;
  logic               last_chip, last_chan;
  logic               accept, chan_skip;
  chip_op_t           op;

  assign accept    = start_valid && (state_q == S_IDLE);
  assign chan_skip = zs_q && !hmap_q[chan_idx];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:      if (start_valid) state_d = S_SOF;
      S_SOF:       if (out_ready) state_d = S_RD_HMAP;
      S_RD_HMAP:   state_d = S_CHK_HMAP;
      S_CHK_HMAP:  state_d = (hmap_q == '0) ? S_NEXT_CHIP : S_WR_ADDR;
      S_WR_ADDR:   if (out_ready) state_d = S_WR_HMAP;
      S_WR_HMAP:   if (out_ready) state_d = S_RD_TAG;
      S_RD_TAG:    if (out_ready) state_d = S_RD_CNT;
      S_RD_CNT:    if (out_ready) state_d = S_CHAN;
      S_CHAN: begin
        if (chan_skip)      state_d = S_NEXT_CHAN;
        else if (out_ready) state_d = S_RD_START;
      end
      S_RD_START:  state_d = S_RD_WORD;
      S_RD_WORD:   if (out_ready && chip_eoc) state_d = S_NEXT_CHAN;
      S_NEXT_CHAN: state_d = last_chan ? S_NEXT_CHIP : S_CHAN;
      S_NEXT_CHIP: state_d = last_chip ? S_INC_PTR : S_RD_HMAP;
      S_INC_PTR:   state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      hmap_q  <= '0;
      evt_q   <= '0;
      zs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        evt_q <= start_evt;
        zs_q  <= zero_supp;
      end
      if (state_q == S_RD_HMAP) hmap_q <= chip_data[CHANS-1:0];
    end
  end

  rdseq_index #(
    .NUM_CHIPS (NUM_CHIPS),
    .CHANS     (CHANS),
    .EVT_W     (EVT_W)
  ) index_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (accept),
    .inc_chip  (state_q == S_NEXT_CHIP && !last_chip),
    .clr_chan  (state_q == S_NEXT_CHIP),
    .inc_chan  (state_q == S_NEXT_CHAN && !last_chan),
    .inc_ptr   (state_q == S_INC_PTR),
    .chip_idx  (chip_idx),
    .chan_idx  (chan_idx),
    .rd_ptr    (evt_rd_ptr),
    .last_chip (last_chip),
    .last_chan (last_chan)
  );

  always_comb begin
    unique case (state_q)
      S_RD_HMAP:  op = OP_HMAP;
      S_RD_TAG:   op = OP_TAG;
      S_RD_CNT:   op = OP_CNT;
      S_RD_START: op = OP_START;
      S_RD_WORD:  op = OP_WORD;
      default:    op = OP_NONE;
    endcase
  end

  assign chip_op   = op;
  assign chip_ack  = (op == OP_HMAP) || (op == OP_START) ||
                     (out_ready && (op == OP_TAG || op == OP_CNT || op == OP_WORD));
  assign chip_sel  = chip_idx;
  assign chip_chan = chan_idx;

  rdseq_frame #(
    .DATA_W (DATA_W),
    .CHANS  (CHANS),
    .CHIP_W (CHIP_W),
    .CHAN_W (CHAN_W),
    .EVT_W  (EVT_W)
  ) frame_i (
    .state     (state_q),
    .chan_skip (chan_skip),
    .evt       (evt_q),
    .chip_idx  (chip_idx),
    .chan_idx  (chan_idx),
    .hmap      (hmap_q),
    .chip_data (chip_data),
    .valid     (out_valid),
    .data      (out_data)
  );

  assign busy        = (state_q != S_IDLE);
  assign start_ready = (state_q == S_IDLE);

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && chip_op == 3'd0));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(state_q)));

  // R6
  word_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_op == 3'd5) |-> out_valid);

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (evt_rd_ptr != $past(evt_rd_ptr)));

endmodule

// File: tb/hitmap_readout_seq_tb_top.sv
module hitmap_readout_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCHIP = 8;
  localparam int NCH   = 8;
  localparam int MAXW  = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [7:0]  start_evt = '0;
  logic        zero_supp = 1'b0;
  logic        busy;
  logic [7:0]  evt_rd_ptr;
  logic [2:0]  chip_sel;
  logic [2:0]  chip_chan;
  logic [2:0]  chip_op;
  logic        chip_ack;
  logic [15:0] chip_data;
  logic        chip_eoc;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [18:0] out_data;

  hitmap_readout_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_evt(start_evt), .zero_supp(zero_supp), .busy(busy), .evt_rd_ptr(evt_rd_ptr),
    .chip_sel(chip_sel), .chip_chan(chip_chan), .chip_op(chip_op), .chip_ack(chip_ack),
    .chip_data(chip_data), .chip_eoc(chip_eoc), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] hm_f(int e, int c);
    if (e == 5 || (e + c) % 3 == 0) return 8'h00;
    return 8'(e * 73 + c * 29 + 5);
  endfunction
  function automatic logic [15:0] tag_f(int e, int c);
    return 16'(e * 256 + 160 + c);
  endfunction
  function automatic logic [15:0] cnt_f(int e, int c);
    return 16'(e * 100 + c * 7 + 1);
  endfunction
  function automatic int nw_f(int e, int c, int ch);
    return 1 + ((e + c + ch) % 3);
  endfunction
  function automatic logic [15:0] word_f(int c, int ch, int k);
    return 16'(c * 4096 + ch * 256 + k);
  endfunction
  function automatic string req_of(logic [2:0] kind);
    case (kind)
      3'd1: return "R2";
      3'd2, 3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  // chip model: same-cycle read data, word counter per channel
  int cur_e = 0;
  int kcnt = 0;
  always_comb begin
    chip_data = 16'hDEAD;
    chip_eoc  = 1'b0;
    case (chip_op)
      3'd1: chip_data = 16'(hm_f(cur_e, int'(chip_sel)));
      3'd2: chip_data = tag_f(cur_e, int'(chip_sel));
      3'd3: chip_data = cnt_f(cur_e, int'(chip_sel));
      3'd5: begin
        chip_data = word_f(int'(chip_sel), int'(chip_chan), kcnt);
        chip_eoc  = (kcnt == nw_f(cur_e, int'(chip_sel), int'(chip_chan)) - 1);
      end
      default: ;
    endcase
  end
  always @(posedge clk) begin
    if (chip_ack && chip_op == 3'd4) kcnt <= 0;
    else if (chip_ack && chip_op == 3'd5) kcnt <= kcnt + 1;
  end

  // output collector with back-pressure patterns
  logic [18:0] got [MAXW];
  logic [18:0] expw [MAXW];
  int ngot = 0;
  int nexp = 0;
  int rmode = 0;
  int cyc = 0;
  logic [7:0] lf = 8'h5A;
  logic prev_stall = 1'b0;
  logic [18:0] prev_data = '0;

  always begin
    @(negedge clk);
    cyc++;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    case (rmode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3 != 0);
      default: out_ready = lf[0] | lf[2];
    endcase
    #1;
    if (prev_stall)
      chk(out_valid && out_data == prev_data, "R8", "stalled word held",
          {out_valid, out_data}, {1'b1, prev_data});
    if (out_valid && out_ready && ngot < MAXW) begin
      got[ngot] = out_data;
      ngot++;
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
  end

  task automatic push(input logic [2:0] kind, input logic [15:0] pl);
    expw[nexp] = {kind, pl};
    nexp++;
  endtask

  task automatic build_exp(input int e, input bit zs, input logic [7:0] evt);
    nexp = 0;
    push(3'd1, 16'(evt));
    for (int c = 0; c < NCHIP; c++) begin
      logic [7:0] hm;
      hm = hm_f(e, c);
      if (hm != 8'h00) begin
        push(3'd2, 16'(c));
        push(3'd3, 16'(hm));
        push(3'd4, tag_f(e, c));
        push(3'd5, cnt_f(e, c));
        for (int ch = 0; ch < NCH; ch++) begin
          if (!(zs && !hm[ch])) begin
            push(3'd6, 16'(ch));
            for (int k = 0; k < nw_f(e, c, ch); k++) push(3'd7, word_f(c, ch, k));
          end
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog expired actual=busy expected=idle");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(!busy && start_ready, "R1", "reset idle", {busy, start_ready}, 2'b01);
    chk(!out_valid, "R1", "reset no output", out_valid, 0);
    chk(evt_rd_ptr == 8'd0, "R9", "reset pointer", evt_rd_ptr, 0);

    for (int e = 0; e < 12; e++) begin
      bit zs;
      logic [7:0] evt;
      int guard;
      zs  = (e % 2 == 1);
      evt = 8'(e * 13 + 200);
      build_exp(e, zs, evt);
      ngot  = 0;
      cur_e = e;
      rmode = e % 3;
      @(negedge clk);
      start_valid = 1'b1;
      start_evt   = evt;
      zero_supp   = zs;
      @(negedge clk);
      start_valid = 1'b0;
      start_evt   = 8'h00;
      zero_supp   = !zs;   // R7: change after capture must not matter
      #2;
      chk(busy && !start_ready, "R1", "busy after start", {busy, start_ready}, 2'b10);
      guard = 0;
      while (busy && guard < 20000) begin
        @(negedge clk);
        #2;
        if (busy) chk(!start_ready, "R1", "start_ready low while busy", start_ready, 0);
        guard++;
      end
      chk(ngot == nexp, zs ? "R7" : "R3", "frame length", ngot, nexp);
      for (int i = 0; i < nexp && i < ngot; i++)
        chk(got[i] == expw[i], req_of(expw[i][18:16]), "frame word", got[i], expw[i]);
      chk(evt_rd_ptr == 8'(e + 1), "R9", "pointer advance", evt_rd_ptr, e + 1);
      chk(!busy && start_ready, "R1", "idle after frame", {busy, start_ready}, 2'b01);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule